// File: doc/BRIEF.md
# Transmit Buffer Descriptor Ring Engine

This block feeds a serial transmitter from a circular table of transmit buffer descriptors kept in a synchronous, word-addressed, 32-bit memory. Each descriptor is eight bytes long. The first memory word holds a 16-bit control/status halfword in its upper half and a 16-bit byte count in its lower half. The second word holds a 32-bit buffer address. The engine reads a descriptor, checks whether software has handed it over, and streams the buffer bytes on a valid/ready byte stream. It then waits for the transmitter to report that the transfer has ended and writes the outcome back into the control/status halfword.

Control bits are numbered from the most significant end. Bit n of the halfword is bit 15-n of the halfword and bit 31-n of the first descriptor word. Bit 0 is the ownership flag (Ready), bit 1 is reserved, bit 2 closes the table (Wrap), bit 3 requests a completion event, and bits 13, 14 and 15 carry the no-acknowledge, underrun and collision results. There is no table-length register. The table ends at the descriptor whose Wrap bit is set, and the engine then goes back to the programmable table base.

Software builds the descriptors and sets Ready. It pulses the demand input whenever the engine is parked on a descriptor it does not own. The engine hands the descriptor back by clearing Ready.

Top module: `txring_engine`

## Requirements
- R1: After reset the engine reads the descriptor at `tableBase`. Its first read is the word at byte address `tableBase` and its second read is the word at `tableBase`+4, both issued as word addresses (byte address divided by 4).
- R2: The first descriptor word supplies the control/status halfword in bits 31:16 and the byte count in bits 15:0. The second word supplies the buffer byte address. Ready is word bit 31, Wrap is word bit 29 and the event-request flag is word bit 28.
- R3: When a fetched descriptor has Ready = 0, the engine sends no byte, writes nothing and issues no further memory access until `txDemand` is pulsed. It then fetches the same descriptor again.
- R4: For a descriptor with Ready = 1 and a non-zero count N, exactly N bytes are presented on `txData`, starting at the buffer address, which may be unaligned. Bytes are read from memory words in big-endian order, so byte offset 0 of a word is bits 31:24. While `txValid` is high and `txReady` is low, `txData` holds its value.
- R5: Completion writes back with a single write to the descriptor's first word with `memBe` = 4'b1100. The written halfword (`memWdata[31:16]`) has Ready and reserved bit 1 cleared. Bits 13, 14 and 15 are set to `xferErr[2]`, `xferErr[1]` and `xferErr[0]`, and every other bit keeps its fetched value.
- R6: After the write-back, the next fetch is at the table base if Wrap was set, and at the current descriptor address + 8 otherwise.
- R7: A count of zero with Ready = 1 presents no bytes, does not wait for `xferDone`, and writes back with all result bits 13..15 cleared.
- R8: In the cycle after the write-back, `errEvent` pulses for one cycle if any result bit is set. Otherwise `txEvent` pulses if the event-request flag was set. The two never occur together.
- R9: An `xferDone` pulse while bytes remain ends the transfer at once. No further byte is presented, and the write-back carries `xferErr`.
- R10: After the last byte is accepted, the engine waits for `xferDone` and only then writes back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tableBase | input | ADDR_W+2 | Byte address of the first descriptor (8-byte aligned) |
| txDemand | input | 1 | Pulse: poll the current descriptor again |
| memRe | output | 1 | Memory read strobe; data is returned on the next cycle |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memBe | output | 4 | Byte enables of a write, bit 3 = bits 31:24 |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after `memRe` |
| txData | output | 8 | Byte to the transmitter |
| txValid | output | 1 | `txData` is valid |
| txReady | input | 1 | Transmitter accepts the byte |
| xferDone | input | 1 | Pulse: transmitter has finished or aborted |
| xferErr | input | 3 | Result with `xferDone`: {no-ack, underrun, collision} |
| txEvent | output | 1 | One-cycle completion event |
| errEvent | output | 1 | One-cycle error event |

## Verification
The streaming path is tried with three patterns. An unaligned five-byte buffer with the transmitter always ready shows whether the big-endian byte order and the word refill at the start offset are right. An aligned six-byte buffer with `txReady` toggling on every cycle separates correct stall holding from a byte that advances or changes under back-pressure. A three-byte buffer that crosses a word boundary tests the refill across that boundary.

The descriptor sequence covers several cases. A zero-length descriptor with Wrap set separates immediate completion from waiting for `xferDone`, and shows that the next fetch returns to the base. A Wrap set on the second descriptor shows that the table length comes from the flag alone. A Ready-clear descriptor, watched over several idle cycles, shows that the engine polls again only on demand.

An abort after three of eight bytes, together with two different result codes, checks that each of bits 13 to 15 is written back and that the error event takes the place of the completion event.

// File: rtl/txring_pkg.sv
package txring_pkg;

  // control/status halfword bits, MSB-first numbering mapped to [15:0]
  localparam int ST_READY = 15;  // bit 0
  localparam int ST_RSVD  = 14;  // bit 1
  localparam int ST_WRAP  = 13;  // bit 2
  localparam int ST_INTR  = 12;  // bit 3
  localparam logic [15:0] ST_KEEP_MASK = 16'h3FF8;

  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 16;
  localparam int ERR_W      = 3;

  typedef enum logic [3:0] {
    S_START, S_FETCH0, S_FETCH1, S_FETCH2, S_IDLE,
    S_BUFRD, S_BUFLD, S_STREAM, S_DONEWAIT, S_WB, S_NEXT
  } ringState_e;

  typedef enum logic [1:0] {
    A_DESC0, A_DESC1, A_BUF
  } addrSel_e;

  typedef struct packed {
    logic     loadBase;
    logic     loadWord0;
    logic     loadWord1;
    logic     loadBufWord;
    logic     advByte;
    logic     capFlags;
    logic     advPtr;
    addrSel_e addrSel;
  } dpCtrl_s;

endpackage

// File: rtl/txring_dp.sv
module txring_dp
  import txring_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int BA_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_s           ctl,
  input  logic [BA_W-1:0]   tableBase,
  input  logic [31:0]       memRdata,
  input  logic [ERR_W-1:0]  xferErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [7:0]        txData,
  output logic              stReady,
  output logic              stInt,
  output logic              lenZero,
  output logic              lastByte,
  output logic              wordEnd,
  output logic              errAny
);

  logic [BA_W-1:0]  descPtr;
  logic [BA_W-1:0]  bytePtr;
  logic [15:0]      status;
  logic [LEN_W-1:0] remLen;
  logic [31:0]      wordReg;
  logic [ERR_W-1:0] errFlags;
  logic [BA_W-1:0]  descWord1;
  logic [15:0]      wbStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr  <= '0;
      bytePtr  <= '0;
      status   <= '0;
      remLen   <= '0;
      wordReg  <= '0;
      errFlags <= '0;
    end else begin
      if (ctl.loadBase) descPtr <= tableBase;
      else if (ctl.advPtr) begin
        if (status[ST_WRAP]) descPtr <= tableBase;
        else                 descPtr <= descPtr + BA_W'(DESC_BYTES);
      end
      if (ctl.loadWord0) begin
        status   <= memRdata[31:16];
        remLen   <= memRdata[15:0];
        errFlags <= '0;
      end else if (ctl.advByte) begin
        remLen <= remLen - 1'b1;
      end
      if (ctl.loadWord1)     bytePtr <= memRdata[BA_W-1:0];
      else if (ctl.advByte)  bytePtr <= bytePtr + 1'b1;
      if (ctl.loadBufWord)   wordReg <= memRdata;
      if (ctl.capFlags)      errFlags <= xferErr;
    end
  end

  assign descWord1 = descPtr + BA_W'(4);

  always_comb begin
    unique case (ctl.addrSel)
      A_DESC1: memAddr = descWord1[BA_W-1:2];
      A_BUF:   memAddr = bytePtr[BA_W-1:2];
      default: memAddr = descPtr[BA_W-1:2];
    endcase
  end

  always_comb begin
    unique case (bytePtr[1:0])
      2'd0: txData = wordReg[31:24];
      2'd1: txData = wordReg[23:16];
      2'd2: txData = wordReg[15:8];
      default: txData = wordReg[7:0];
    endcase
  end

  assign wbStatus = (status & ST_KEEP_MASK) | {{(16-ERR_W){1'b0}}, errFlags};
  assign memWdata = {wbStatus, 16'h0000};

  assign stReady  = status[ST_READY];
  assign stInt    = status[ST_INTR];
  assign lenZero  = (remLen == '0);
  assign lastByte = (remLen == LEN_W'(1));
  assign wordEnd  = (bytePtr[1:0] == 2'b11);
  assign errAny   = |errFlags;

  // R4
  byte_count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advByte |=> remLen == $past(remLen) - 1'b1);

  // R5
  wb_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWdata[31] && !memWdata[30]);

endmodule

// File: rtl/txring_ctl.sv
module txring_ctl
  import txring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txDemand,
  input  logic    txReady,
  input  logic    xferDone,
  input  logic    stReady,
  input  logic    stInt,
  input  logic    lenZero,
  input  logic    lastByte,
  input  logic    wordEnd,
  input  logic    errAny,
  output dpCtrl_s ctl,
  output logic    memRe,
  output logic    memWe,
  output logic    txValid,
  output logic    txEvent,
  output logic    errEvent
);

  ringState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_START;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.addrSel = A_DESC0;
    memRe       = 1'b0;
    memWe       = 1'b0;
    txValid     = 1'b0;
    txEvent     = 1'b0;
    errEvent    = 1'b0;
    unique case (state)
      S_START: begin
        ctl.loadBase = 1'b1;
        nextState    = S_FETCH0;
      end
      S_FETCH0: begin
        memRe     = 1'b1;
        nextState = S_FETCH1;
      end
      S_FETCH1: begin
        memRe         = 1'b1;
        ctl.addrSel   = A_DESC1;
        ctl.loadWord0 = 1'b1;
        nextState     = S_FETCH2;
      end
      S_FETCH2: begin
        ctl.loadWord1 = 1'b1;
        if (!stReady)     nextState = S_IDLE;
        else if (lenZero) nextState = S_WB;
        else              nextState = S_BUFRD;
      end
      S_IDLE: begin
        if (txDemand) nextState = S_FETCH0;
      end
      S_BUFRD: begin
        memRe       = 1'b1;
        ctl.addrSel = A_BUF;
        if (xferDone) begin
          ctl.capFlags = 1'b1;
          nextState    = S_WB;
        end else begin
          nextState = S_BUFLD;
        end
      end
      S_BUFLD: begin
        ctl.loadBufWord = 1'b1;
        if (xferDone) begin
          ctl.capFlags = 1'b1;
          nextState    = S_WB;
        end else begin
          nextState = S_STREAM;
        end
      end
      S_STREAM: begin
        if (xferDone) begin
          ctl.capFlags = 1'b1;
          nextState    = S_WB;
        end else begin
          txValid = 1'b1;
          if (txReady) begin
            ctl.advByte = 1'b1;
            if (lastByte)     nextState = S_DONEWAIT;
            else if (wordEnd) nextState = S_BUFRD;
          end
        end
      end
      S_DONEWAIT: begin
        if (xferDone) begin
          ctl.capFlags = 1'b1;
          nextState    = S_WB;
        end
      end
      S_WB: begin
        memWe     = 1'b1;
        nextState = S_NEXT;
      end
      S_NEXT: begin
        ctl.advPtr = 1'b1;
        errEvent   = errAny;
        txEvent    = stInt && !errAny;
        nextState  = S_FETCH0;
      end
      default: nextState = S_START;
    endcase
  end

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (!memRe && !memWe && !txValid));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH2 && stReady && lenZero) |=> memWe);

  // R10
  wait_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONEWAIT && !xferDone) |=> !memWe);

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int BA_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BA_W-1:0]   tableBase,
  input  logic              txDemand,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              xferDone,
  input  logic [2:0]        xferErr,
  output logic              txEvent,
  output logic              errEvent
);

  dpCtrl_s ctl;
  logic stReady, stInt, lenZero, lastByte, wordEnd, errAny;

  txring_ctl ctl_i (
    .clk(clk), .rstN(rstN), .txDemand(txDemand), .txReady(txReady),
    .xferDone(xferDone), .stReady(stReady), .stInt(stInt),
    .lenZero(lenZero), .lastByte(lastByte), .wordEnd(wordEnd),
    .errAny(errAny), .ctl(ctl), .memRe(memRe), .memWe(memWe),
    .txValid(txValid), .txEvent(txEvent), .errEvent(errEvent)
  );

  txring_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tableBase(tableBase),
    .memRdata(memRdata), .xferErr(xferErr), .memAddr(memAddr),
    .memWdata(memWdata), .txData(txData), .stReady(stReady),
    .stInt(stInt), .lenZero(lenZero), .lastByte(lastByte),
    .wordEnd(wordEnd), .errAny(errAny)
  );

  assign memBe = memWe ? 4'b1100 : 4'b0000;

  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (xferDone || (txValid && $stable(txData))));

  // R8
  event_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txEvent && errEvent));

  // R8
  event_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEvent || errEvent) |-> $past(memWe));

endmodule

// File: tb/txring_engine_tb_top.sv
module txring_engine_tb_top;

  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W+1:0] tableBase = 18'h40;
  logic txDemand = 1'b0;
  logic memRe, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic [7:0] txData;
  logic txValid;
  logic txReady = 1'b0;
  logic xferDone = 1'b0;
  logic [2:0] xferErr = 3'b000;
  logic txEvent, errEvent;

  always #10 clk = ~clk;

  txring_engine #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .tableBase(tableBase), .txDemand(txDemand),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .txData(txData),
    .txValid(txValid), .txReady(txReady), .xferDone(xferDone),
    .xferErr(xferErr), .txEvent(txEvent), .errEvent(errEvent)
  );

  function automatic logic [7:0] pat(input logic [9:0] a);
    if (a < 10'h80) return 8'h00;
    return (a[7:0] * 8'd7) + ({6'b0, a[9:8]} * 8'd31);
  endfunction

  // memory model and monitors
  logic [31:0] mem [0:255];
  logic tbWe = 1'b0;
  logic [7:0] tbAddr = '0;
  logic [31:0] tbData = '0;
  int cyc = 0, readCnt = 0, wrCnt = 0, hsCnt = 0, txEvCnt = 0, errEvCnt = 0;
  int wrCyc = 0, evCyc = 0;
  logic [15:0] firstRd [0:1];
  logic [15:0] lastRd, prevRd;
  logic [15:0] lastWrAddr;
  logic [31:0] lastWrData;
  logic [3:0]  lastWrBe;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= {pat(10'(4*i)), pat(10'(4*i+1)), pat(10'(4*i+2)), pat(10'(4*i+3))};
      memRdata <= '0;
    end else begin
      if (tbWe) mem[tbAddr] <= tbData;
      if (memRe) begin
        memRdata <= mem[memAddr[7:0]];
        if (readCnt < 2) firstRd[readCnt] <= memAddr;
        prevRd <= lastRd;
        lastRd <= memAddr;
        readCnt <= readCnt + 1;
      end
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[7:0]][8*b +: 8] <= memWdata[8*b +: 8];
        wrCnt <= wrCnt + 1;
        wrCyc <= cyc;
        lastWrAddr <= memAddr;
        lastWrData <= memWdata;
        lastWrBe <= memBe;
      end
      if (txValid && txReady) hsCnt <= hsCnt + 1;
      if (txEvent) begin txEvCnt <= txEvCnt + 1; evCyc <= cyc; end
      if (errEvent) begin errEvCnt <= errEvCnt + 1; evCyc <= cyc; end
    end
  end

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [9:0] byteAddr, input logic [31:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = byteAddr[9:2]; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putDesc(input logic [9:0] a, input logic [15:0] st,
                         input logic [15:0] len, input logic [31:0] ptr);
    poke(a, {st, len});
    poke(a + 10'd4, ptr);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDemand();
    @(negedge clk); txDemand = 1'b1;
    @(negedge clk); txDemand = 1'b0;
  endtask

  // transmitter model: takes bytes, then pulses done with a result
  logic [7:0] got [0:15];
  int gotCnt;
  bit stallOk;

  task automatic runXfer(input int take, input bit stall, input logic [2:0] err);
    bit holdV = 1'b0;
    logic [7:0] holdD = '0;
    int k = 0;
    gotCnt = 0; stallOk = 1'b1;
    while (gotCnt < take && k < 2000) begin
      @(negedge clk);
      txReady = stall ? k[0] : 1'b1;
      k++;
      #1;
      if (holdV && !(txValid && txData == holdD)) stallOk = 1'b0;
      if (txValid && txReady) begin
        got[gotCnt] = txData; gotCnt++; holdV = 1'b0;
      end else if (txValid) begin
        holdV = 1'b1; holdD = txData;
      end
    end
    @(negedge clk);
    txReady = 1'b0; xferDone = 1'b1; xferErr = err;
    @(negedge clk);
    xferDone = 1'b0; xferErr = 3'b000;
    waitCyc(2);
  endtask

  task automatic checkBytes(input string req, input int n, input logic [9:0] ptr);
    check(gotCnt == n, req, gotCnt, n);
    for (int i = 0; i < gotCnt; i++)
      check(got[i] == pat(ptr + 10'(i)), req, got[i], pat(ptr + 10'(i)));
  endtask

  task automatic checkWb(input string req, input int wrBefore, input logic [15:0] wAddr,
                         input logic [15:0] expSt);
    check(wrCnt == wrBefore + 1, req, wrCnt, wrBefore + 1);
    check(lastWrAddr == wAddr, req, lastWrAddr, wAddr);
    check(lastWrBe == 4'b1100, req, lastWrBe, 4'b1100);
    check(lastWrData[31:16] == expSt, req, lastWrData[31:16], expSt);
  endtask

  task automatic testResetIdle();
    @(negedge clk);
    check(!txValid && !memWe && !txEvent && !errEvent, "R1 reset outputs", txValid, 0);
    waitCyc(10);
    check(readCnt == 2, "R1 fetch count", readCnt, 2);
    check(firstRd[0] == 16'h10, "R1 first read", firstRd[0], 16'h10);
    check(firstRd[1] == 16'h11, "R1 second read", firstRd[1], 16'h11);
    check(wrCnt == 0 && hsCnt == 0, "R3 not-ready no action", wrCnt + hsCnt, 0);
  endtask

  task automatic testNoPollWithoutDemand();
    putDesc(10'h40, 16'hD000, 16'd5, 32'h101);
    putDesc(10'h48, 16'h8080, 16'd6, 32'h200);
    putDesc(10'h50, 16'hB000, 16'd0, 32'h0);
    waitCyc(10);
    check(readCnt == 2, "R3 no poll without demand", readCnt, 2);
    check(hsCnt == 0, "R3 no bytes while parked", hsCnt, 0);
  endtask

  task automatic testUnalignedBurst();
    int w0 = wrCnt, e0 = txEvCnt;
    pulseDemand();
    runXfer(5, 1'b0, 3'b000);
    checkBytes("R4 unaligned big-endian", 5, 10'h101);
    checkWb("R5 writeback desc0 (R2 fields)", w0, 16'h10, 16'h1000);
    check(txEvCnt == e0 + 1, "R8 txEvent on request", txEvCnt, e0 + 1);
    check(evCyc - wrCyc == 1, "R8 event timing", evCyc - wrCyc, 1);
    check(hsCnt == 5, "R4 handshake count", hsCnt, 5);
  endtask

  task automatic testStalledBurst();
    int w0 = wrCnt, e0 = txEvCnt + errEvCnt;
    runXfer(6, 1'b1, 3'b000);
    checkBytes("R4 stalled stream", 6, 10'h200);
    check(stallOk, "R4 data held while stalled", stallOk, 1);
    checkWb("R5 keeps other bits", w0, 16'h12, 16'h0080);
    check(txEvCnt + errEvCnt == e0, "R8 no event without request", txEvCnt + errEvCnt, e0);
  endtask

  task automatic testZeroLenWrap();
    int w0 = wrCnt, h0 = hsCnt, e0 = txEvCnt;
    waitCyc(12);
    checkWb("R7 zero length writeback", w0, 16'h14, 16'h3000);
    check(hsCnt == h0, "R7 no bytes for zero length", hsCnt, h0);
    check(txEvCnt == e0 + 1, "R7 zero length event", txEvCnt, e0 + 1);
    check(prevRd == 16'h10 && lastRd == 16'h11, "R6 wrap to base", {prevRd, lastRd}, 32'h00100011);
    begin
      int r0 = readCnt;
      waitCyc(8);
      check(readCnt == r0, "R3 parked after wrap", readCnt, r0);
    end
  endtask

  task automatic testAbortAndWrapMid();
    int w0, e0, t0, h0;
    putDesc(10'h40, 16'h9000, 16'd8, 32'h300);
    putDesc(10'h48, 16'hA000, 16'd3, 32'h2FE);
    w0 = wrCnt; e0 = errEvCnt; t0 = txEvCnt; h0 = hsCnt;
    pulseDemand();
    runXfer(3, 1'b0, 3'b010);
    checkBytes("R9 bytes before abort", 3, 10'h300);
    check(hsCnt == h0 + 3, "R9 no byte after abort", hsCnt, h0 + 3);
    checkWb("R9 abort writeback", w0, 16'h10, 16'h1002);
    check(errEvCnt == e0 + 1 && txEvCnt == t0, "R8 error replaces completion", errEvCnt, e0 + 1);
    w0 = wrCnt; e0 = errEvCnt;
    runXfer(3, 1'b0, 3'b101);
    checkBytes("R4 crossing word boundary", 3, 10'h2FE);
    checkWb("R5 nak and collision", w0, 16'h12, 16'h2005);
    check(errEvCnt == e0 + 1, "R8 error event", errEvCnt, e0 + 1);
    waitCyc(6);
    check(prevRd == 16'h10 && lastRd == 16'h11, "R6 wrap from second entry", {prevRd, lastRd}, 32'h00100011);
  endtask

  task automatic testDoneWait();
    int w0;
    putDesc(10'h40, 16'h8000, 16'd1, 32'h180);
    w0 = wrCnt;
    pulseDemand();
    waitCyc(6);
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    waitCyc(5);
    check(wrCnt == w0, "R10 waits for done", wrCnt, w0);
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    waitCyc(2);
    check(wrCnt == w0 + 1, "R10 writes after done", wrCnt, w0 + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testResetIdle();
    testNoPollWithoutDemand();
    testUnalignedBurst();
    testStalledBurst();
    testZeroLenWrap();
    testAbortAndWrapMid();
    testDoneWait();
    finished = 1'b1;
  end

  initial begin
    int n = 0;
    while (!finished && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected finish", n);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule